// File: doc/BRIEF.md
# Tree Search Road Refiner

This block takes one coarse road, as found by an upstream pattern-matching stage, and narrows it to the finer roads that the event's hits actually support. Each accepted road is treated as the root of a tree (depth 0). Every deeper level halves the superstrip on every layer. The children of a node are held together as one contiguous block of entries in a pattern RAM. For each child, an entry records which half of the parent region it occupies on each layer. The engine walks the tree depth-first with an explicit work stack. It reads each child of the node it is visiting and drops children that the hits do not support. Surviving children are pushed for further descent. Nodes that reach the deepest level are emitted as thin road IDs.

The hits are fine offsets inside the coarse superstrip, with a fixed number of hit slots per layer and one valid flag per slot. They are captured when a road is accepted. The pattern RAM is filled through a simple write port, which may be used at any time. A read and a write to the same address in the same cycle return the old content. The controller has four states: IDLE (waiting), POP (take the next node off the stack, or finish), FETCH (issue the RAM read for the current child slot) and TEST (judge that child and step to the next slot). The transitions are:

- IDLE→POP when a start is accepted.
- POP→POP after emitting a leaf.
- POP→FETCH for an inner node.
- POP→IDLE with a done pulse when the stack is empty.
- FETCH→TEST always.
- TEST→FETCH while child slots remain.
- TEST→POP after slot 0.

Top module: `tsr_refiner`

## Requirements
- R1: After reset, `busy`, `done` and `out_valid` are all low.
- R2: `start` is taken only while `busy` is low; a `start` raised while busy is ignored, and the road and hits of the search in progress are unchanged.
- R3: The entry for child slot s of node n at depth d sits at address base(d) + n*BLK + s, with base(0)=0 and base(1)=NROAD*BLK (32 at defaults). In a pattern word, bit NL is the valid flag and bit l (l < NL) selects the half of the parent region on layer l (1 = upper half).
- R4: A child matches only if its valid flag is set and, on every layer, some valid hit lies in the child's region. At depth d that region is the set of offsets whose top d bits equal the path of half bits from depth 1 to d. Entries without the valid flag never match.
- R5: The child of node n in slot s has ID n*BLK + s. Only nodes at depth MAXD are emitted on `out_id`, one per `out_valid` cycle, and the top ROAD_W bits of every emitted ID equal the accepted road.
- R6: Within one search the emitted IDs rise strictly (all depth-1 slots in ascending order, each followed by its depth-2 slots in ascending order).
- R7: After the last emission, `done` pulses for exactly one cycle with `busy` low; a road with no surviving leaf gives `done` and no `out_valid`.
- R8: A `start` held high during the `done` cycle is taken in that cycle, so the next search begins back to back.
- R9: Hit slots whose valid flag is low are ignored. Layer l, slot h occupies `hit_pos[(l*NH+h)*FW +: FW]` and `hit_ok[l*NH+h]`.
- R10: A road whose whole tree matches emits all BLK^MAXD leaves (16 at defaults) without losing any entry on the work stack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request to refine the road on `road_id` |
| road_id | input | ROAD_W | Coarse road number (depth-0 node) |
| hit_pos | input | NL*NH*FW | Fine hit offsets per layer and slot |
| hit_ok | input | NL*NH | Valid flag per hit slot |
| pat_we | input | 1 | Pattern RAM write enable |
| pat_addr | input | AW | Pattern RAM write address |
| pat_data | input | NL+1 | Pattern word: valid flag and half bits per layer |
| busy | output | 1 | A search is in progress |
| out_valid | output | 1 | `out_id` carries a thin road |
| out_id | output | ROAD_W+MAXD*log2(BLK) | Thin road ID at depth MAXD |
| done | output | 1 | One-cycle pulse at the end of a search |

## Verification
The end of one search and the start of the next can land in the same cycle. `done` rises with `busy` low, and a `start` held high in that cycle is taken at once. The bench provokes this by raising `start` for a second road while the first is still running. It then checks three things: the first road's thin IDs are untouched by the early request, `busy` is low in the `done` cycle and high in the next one, and the second road yields its own full list of leaves. Order, pruning and hit masking are judged against a model of the tree that the bench builds from the pattern words it wrote.

// File: rtl/tsr_pkg.sv
package tsr_pkg;

    typedef enum logic [1:0] {
        S_IDLE,
        S_POP,
        S_FETCH,
        S_TEST
    } tsr_state_e;

    // Start address of the child blocks of depth-d nodes; with d = depth
    // limit it gives the total number of entries.
    function automatic int tsr_level_base(int nroad, int blk, int d);
        int sum;
        int width;
        sum   = 0;
        width = nroad * blk;
        for (int k = 0; k < d; k++) begin
            sum   = sum + width;
            width = width * blk;
        end
        return sum;
    endfunction

endpackage

// File: rtl/tsr_pattern_ram.sv
module tsr_pattern_ram #(
    parameter int DEPTH = 160,
    parameter int WW    = 5,
    parameter int AW    = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [WW-1:0] wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [WW-1:0] rdata
);
    logic [WW-1:0] mem [DEPTH];

    // Read returns the content before a same-cycle write.
    always_ff @(posedge clk) begin
        if (re) begin
            rdata <= mem[raddr];
        end
        if (we) begin
            mem[waddr] <= wdata;
        end
    end
endmodule

// File: rtl/tsr_stack.sv
module tsr_stack #(
    parameter int W     = 8,
    parameter int DEPTH = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] din,
    output logic [W-1:0] top,
    output logic         empty,
    output logic         full
);
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [1 << CW];
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (push) begin
            mem[cnt] <= din;
            cnt      <= cnt + CW'(1);
        end else if (pop) begin
            cnt <= cnt - CW'(1);
        end
    end

    assign top   = mem[cnt - CW'(1)];
    assign empty = (cnt == '0);
    assign full  = (cnt == CW'(DEPTH));
endmodule

// File: rtl/tsr_match.sv
module tsr_match #(
    parameter int NL = 4,
    parameter int NH = 2,
    parameter int FW = 4,
    parameter int DW = 2
) (
    input  logic [NL*FW-1:0]    pref_in,
    input  logic [NL-1:0]       half,
    input  logic                entry_ok,
    input  logic [DW-1:0]       dc,
    input  logic [NL*NH*FW-1:0] hits,
    input  logic [NL*NH-1:0]    hits_ok,
    output logic [NL*FW-1:0]    pref_out,
    output logic                hit
);
    logic [FW-1:0] mask;
    logic [FW-1:0] bitsel;
    logic [NL-1:0] layer_ok;

    // Top dc bits define the region; the new path bit sits at FW-dc.
    assign mask   = ~({FW{1'b1}} >> dc);
    assign bitsel = {1'b1, {(FW-1){1'b0}}} >> (dc - DW'(1));

    for (genvar l = 0; l < NL; l++) begin : g_layer
        logic [FW-1:0] region;
        logic [NH-1:0] slot_ok;

        assign region = pref_in[l*FW +: FW] | (half[l] ? bitsel : '0);
        assign pref_out[l*FW +: FW] = region;

        for (genvar h = 0; h < NH; h++) begin : g_hit
            assign slot_ok[h] = hits_ok[l*NH+h]
                && ((hits[(l*NH+h)*FW +: FW] & mask) == region);
        end

        assign layer_ok[l] = |slot_ok;
    end

    assign hit = entry_ok && (&layer_ok);
endmodule

// File: rtl/tsr_refiner.sv
module tsr_refiner
    import tsr_pkg::*;
#(
    parameter int NL     = 4,
    parameter int NH     = 2,
    parameter int FW     = 4,
    parameter int ROAD_W = 3,
    parameter int BLK    = 4,
    parameter int MAXD   = 2,
    localparam int SW    = $clog2(BLK),
    localparam int OID_W = ROAD_W + MAXD * SW,
    localparam int NROAD = 1 << ROAD_W,
    localparam int RAM_N = tsr_level_base(NROAD, BLK, MAXD),
    localparam int AW    = $clog2(RAM_N),
    localparam int WW    = NL + 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [ROAD_W-1:0]     road_id,
    input  logic [NL*NH*FW-1:0]   hit_pos,
    input  logic [NL*NH-1:0]      hit_ok,
    input  logic                  pat_we,
    input  logic [AW-1:0]         pat_addr,
    input  logic [WW-1:0]         pat_data,
    output logic                  busy,
    output logic                  out_valid,
    output logic [OID_W-1:0]      out_id,
    output logic                  done
);
    localparam int DW     = $clog2(MAXD + 1);
    localparam int PW     = NL * FW;
    localparam int SDEPTH = MAXD * (BLK - 1) + 1;

    typedef struct packed {
        logic [DW-1:0]    depth;
        logic [OID_W-1:0] id;
        logic [PW-1:0]    pref;
    } node_t;

    localparam int NW = $bits(node_t);

    tsr_state_e state, nxt;

    node_t                cur;
    node_t                stk_din;
    logic [NW-1:0]        stk_top_raw;
    node_t                stk_top;
    logic                 stk_push, stk_pop, stk_empty, stk_full;
    logic [SW-1:0]        slot;
    logic [ROAD_W-1:0]    road_q;
    logic [NL*NH*FW-1:0]  hit_q;
    logic [NL*NH-1:0]     ok_q;
    logic [WW-1:0]        rd_data;
    logic [AW-1:0]        rd_addr;
    logic                 rd_en;
    logic [AW-1:0]        lvl_base [1 << DW];
    logic                 child_hit;
    logic [PW-1:0]        child_pref;
    logic [DW-1:0]        child_depth;
    logic                 accept;

    // Per-depth start addresses of child blocks
    for (genvar g = 0; g < (1 << DW); g++) begin : g_base
        if (g < MAXD) begin : g_used
            assign lvl_base[g] = AW'(tsr_level_base(NROAD, BLK, g));
        end else begin : g_unused
            assign lvl_base[g] = '0;
        end
    end

    assign busy        = (state != S_IDLE);
    assign accept      = (state == S_IDLE) && start;
    assign stk_top     = node_t'(stk_top_raw);
    assign child_depth = cur.depth + DW'(1);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // Next state
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:  if (start) nxt = S_POP;
            S_POP: begin
                if (stk_empty) begin
                    nxt = S_IDLE;
                end else if (stk_top.depth == DW'(MAXD)) begin
                    nxt = S_POP;
                end else begin
                    nxt = S_FETCH;
                end
            end
            S_FETCH: nxt = S_TEST;
            S_TEST:  nxt = (slot == '0) ? S_POP : S_FETCH;
        endcase
    end

    // Stack and RAM control
    always_comb begin
        stk_push = accept || ((state == S_TEST) && child_hit);
        stk_pop  = (state == S_POP) && !stk_empty;
        if (accept) begin
            stk_din.depth = '0;
            stk_din.id    = OID_W'(road_id);
            stk_din.pref  = '0;
        end else begin
            stk_din.depth = child_depth;
            stk_din.id    = OID_W'({cur.id, slot});
            stk_din.pref  = child_pref;
        end
        rd_en   = (state == S_FETCH);
        rd_addr = lvl_base[cur.depth] + AW'({cur.id, slot});
    end

    // Outputs and datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_id    <= '0;
            done      <= 1'b0;
            cur       <= '0;
            slot      <= '0;
            road_q    <= '0;
            hit_q     <= '0;
            ok_q      <= '0;
        end else begin
            out_valid <= 1'b0;
            done      <= 1'b0;
            unique case (state)
                S_IDLE: begin
                    if (start) begin
                        road_q <= road_id;
                        hit_q  <= hit_pos;
                        ok_q   <= hit_ok;
                    end
                end
                S_POP: begin
                    if (stk_empty) begin
                        done <= 1'b1;
                    end else begin
                        cur  <= stk_top;
                        slot <= SW'(BLK - 1);
                        if (stk_top.depth == DW'(MAXD)) begin
                            out_valid <= 1'b1;
                            out_id    <= stk_top.id;
                        end
                    end
                end
                S_FETCH: begin
                end
                S_TEST: begin
                    slot <= slot - SW'(1);
                end
            endcase
        end
    end

    tsr_pattern_ram #(
        .DEPTH (RAM_N),
        .WW    (WW),
        .AW    (AW)
    ) u_ram (
        .clk   (clk),
        .we    (pat_we),
        .waddr (pat_addr),
        .wdata (pat_data),
        .re    (rd_en),
        .raddr (rd_addr),
        .rdata (rd_data)
    );

    tsr_stack #(
        .W     (NW),
        .DEPTH (SDEPTH)
    ) u_stack (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (stk_push),
        .pop   (stk_pop),
        .din   (stk_din),
        .top   (stk_top_raw),
        .empty (stk_empty),
        .full  (stk_full)
    );

    tsr_match #(
        .NL (NL),
        .NH (NH),
        .FW (FW),
        .DW (DW)
    ) u_match (
        .pref_in  (cur.pref),
        .half     (rd_data[NL-1:0]),
        .entry_ok (rd_data[NL]),
        .dc       (child_depth),
        .hits     (hit_q),
        .hits_ok  (ok_q),
        .pref_out (child_pref),
        .hit      (child_hit)
    );
endmodule

// File: rtl/tsr_refiner_chk.sv
module tsr_refiner_chk #(
    parameter int ROAD_W = 3,
    parameter int OID_W  = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic              out_valid,
    input logic [OID_W-1:0]  out_id,
    input logic              done,
    input logic              push,
    input logic              stk_full,
    input logic [ROAD_W-1:0] road_q
);
    logic [OID_W-1:0] last_id;
    logic             seen;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen    <= 1'b0;
            last_id <= '0;
        end else if (start && !busy) begin
            seen <= 1'b0;
        end else if (out_valid) begin
            seen    <= 1'b1;
            last_id <= out_id;
        end
    end

    a_r2_start_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    a_r5_emit_in_search: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (busy && !done));

    a_r5_root_prefix: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_id[OID_W-1 -: ROAD_W] == road_q));

    a_r6_rising_ids: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && seen) |-> (out_id > last_id));

    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r7_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    a_r10_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !stk_full);
endmodule

bind tsr_refiner tsr_refiner_chk #(
    .ROAD_W (ROAD_W),
    .OID_W  (OID_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .busy      (busy),
    .out_valid (out_valid),
    .out_id    (out_id),
    .done      (done),
    .push      (stk_push),
    .stk_full  (stk_full),
    .road_q    (road_q)
);

// File: tb/sim_tsr_refiner.sv
module sim_tsr_refiner;
    localparam int NL = 4, NH = 2, FW = 4, ROAD_W = 3, BLK = 4, MAXD = 2;
    localparam int OID_W = 7, AW = 8, WW = 5, RAM_N = 160, BASE1 = 32;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                start = 1'b0;
    logic [ROAD_W-1:0]   road_id = '0;
    logic [NL*NH*FW-1:0] hit_pos;
    logic [NL*NH-1:0]    hit_ok;
    logic                pat_we = 1'b0;
    logic [AW-1:0]       pat_addr = '0;
    logic [WW-1:0]       pat_data = '0;
    logic                busy, out_valid, done;
    logic [OID_W-1:0]    out_id;

    int nchk = 0, nfail = 0, cycles = 0;
    bit finished = 0;
    logic [WW-1:0] pat [RAM_N];
    logic [FW-1:0] hp [NL][NH];
    bit            hv [NL][NH];
    int got_ids [64]; int got_n;
    int exp_ids [64]; int exp_n;

    always #2 clk = ~clk;

    tsr_refiner u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .road_id(road_id),
        .hit_pos(hit_pos), .hit_ok(hit_ok), .pat_we(pat_we),
        .pat_addr(pat_addr), .pat_data(pat_data), .busy(busy),
        .out_valid(out_valid), .out_id(out_id), .done(done)
    );

    always_comb begin
        for (int l = 0; l < NL; l++) begin
            for (int h = 0; h < NH; h++) begin
                hit_pos[(l*NH+h)*FW +: FW] = hp[l][h];
                hit_ok[l*NH+h]             = hv[l][h];
            end
        end
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 200000 && !finished) begin
            finished = 1;
            nchk++; nfail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 200000);
            $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    end

    task automatic chk(bit ok, string req, int act, int expv);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic wr(int addr, logic [WW-1:0] data);
        @(negedge clk);
        pat_we = 1'b1; pat_addr = AW'(addr); pat_data = data;
        pat[addr] = data;
        @(negedge clk);
        pat_we = 1'b0;
    endtask

    task automatic set_hits(logic [FW-1:0] v);
        for (int l = 0; l < NL; l++)
            for (int h = 0; h < NH; h++) begin
                hp[l][h] = v; hv[l][h] = 1'b1;
            end
    endtask

    function automatic bit region_hit(int l, int d, int path);
        for (int h = 0; h < NH; h++)
            if (hv[l][h] && (int'(hp[l][h]) >> (FW - d)) == path) return 1'b1;
        return 1'b0;
    endfunction

    // Reference tree walk from the written pattern words (R3, R4, R5, R6, R9)
    task automatic model(int road);
        exp_n = 0;
        for (int s1 = 0; s1 < BLK; s1++) begin
            int n1; bit ok1;
            n1 = road * BLK + s1;
            ok1 = pat[n1][NL];
            for (int l = 0; l < NL; l++)
                if (!region_hit(l, 1, int'(pat[n1][l]))) ok1 = 0;
            if (ok1) begin
                for (int s2 = 0; s2 < BLK; s2++) begin
                    int a2; bit ok2;
                    a2 = BASE1 + n1 * BLK + s2;
                    ok2 = pat[a2][NL];
                    for (int l = 0; l < NL; l++)
                        if (!region_hit(l, 2, int'({pat[n1][l], pat[a2][l]}))) ok2 = 0;
                    if (ok2) begin
                        exp_ids[exp_n] = n1 * BLK + s2;
                        exp_n++;
                    end
                end
            end
        end
    endtask

    task automatic collect();
        int guard;
        got_n = 0; guard = 0;
        forever begin
            @(negedge clk);
            guard++;
            if (out_valid && got_n < 64) begin
                got_ids[got_n] = int'(out_id);
                got_n++;
            end
            if (done) break;
            if (guard > 5000) begin
                chk(0, "watchdog-search", guard, 5000);
                break;
            end
        end
    endtask

    task automatic launch(int road);
        @(negedge clk);
        start = 1'b1; road_id = ROAD_W'(road);
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic cmp_list(string req);
        chk(got_n == exp_n, {req, " leaf count"}, got_n, exp_n);
        for (int i = 0; i < got_n && i < exp_n; i++)
            chk(got_ids[i] == exp_ids[i], {req, " leaf id"}, got_ids[i], exp_ids[i]);
    endtask

    task automatic t_reset();
        chk(busy == 1'b0, "R1 busy", int'(busy), 0);
        chk(done == 1'b0, "R1 done", int'(done), 0);
        chk(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
    endtask

    task automatic t_empty_tree();
        set_hits(4'h0);
        launch(2);
        collect();
        chk(got_n == 0, "R7 no leaf on empty tree", got_n, 0);
        chk(busy == 1'b0, "R7 busy low in done cycle", int'(busy), 0);
        @(negedge clk);
        chk(done == 1'b0, "R7 done one cycle", int'(done), 0);
    endtask

    task automatic fill_full(int road);
        for (int s = 0; s < BLK; s++) wr(road * BLK + s, 5'b10000);
        for (int n = 0; n < BLK * BLK; n++) wr(BASE1 + road * BLK * BLK + n, 5'b10000);
    endtask

    task automatic t_full_tree();
        fill_full(5);
        set_hits(4'h0);
        model(5);
        launch(5);
        collect();
        chk(exp_n == 16, "R10 model full count", exp_n, 16);
        cmp_list("R10");
        for (int i = 1; i < got_n; i++)
            chk(got_ids[i] > got_ids[i-1], "R6 ascending", got_ids[i], got_ids[i-1] + 1);
        chk(got_n > 0 && got_ids[0] == 80, "R5 first thin id", got_n > 0 ? got_ids[0] : -1, 80);
    endtask

    task automatic fill_mixed(int road);
        for (int s = 0; s < BLK; s++) begin
            int a; a = road * BLK + s;
            wr(a, {1'(a % 3 != 0), 3'b000, 1'(a & 1)});
        end
        for (int n = 0; n < BLK * BLK; n++) begin
            int a; a = BASE1 + road * BLK * BLK + n;
            wr(a, {1'(a % 3 != 0), 3'b000, 1'(a & 1)});
        end
    endtask

    task automatic mixed_hits();
        set_hits(4'h2);
        hp[0][0] = 4'h1; hp[0][1] = 4'hC;
    endtask

    task automatic t_pruning();
        fill_mixed(3);
        mixed_hits();
        model(3);
        launch(3);
        collect();
        chk(exp_n == 2, "R4 model pruned count", exp_n, 2);
        cmp_list("R4");
    endtask

    task automatic t_hit_mask();
        set_hits(4'h0);
        hv[2][0] = 1'b0; hp[2][1] = 4'hF;
        launch(5);
        collect();
        chk(got_n == 0, "R9 masked hit ignored", got_n, 0);
        set_hits(4'h0);
        hv[2][0] = 1'b0; hp[2][1] = 4'h3;
        model(5);
        launch(5);
        collect();
        chk(exp_n == 16, "R9 model valid slot", exp_n, 16);
        cmp_list("R9");
    endtask

    task automatic t_address_map();
        wr(6 * BLK + 2, 5'b11010);
        wr(BASE1 + 26 * BLK + 1, 5'b10110);
        set_hits(4'h0);
        hp[0][0] = 4'h1; hp[1][0] = 4'hD; hp[2][0] = 4'h5; hp[3][0] = 4'h9;
        for (int l = 0; l < NL; l++) hv[l][1] = 1'b0;
        launch(6);
        collect();
        chk(got_n == 1, "R3 single entry count", got_n, 1);
        chk(got_n > 0 && got_ids[0] == 105, "R3 mapped id", got_n > 0 ? got_ids[0] : -1, 105);
    endtask

    task automatic t_back_to_back();
        int first_exp_n;
        int first_exp [64];
        mixed_hits();
        model(3);
        first_exp_n = exp_n;
        for (int i = 0; i < exp_n; i++) first_exp[i] = exp_ids[i];
        @(negedge clk);
        start = 1'b1; road_id = 3'd3;
        @(negedge clk);
        // start stays high with another road while busy
        road_id = 3'd5;
        set_hits(4'h0);
        collect();
        exp_n = first_exp_n;
        for (int i = 0; i < exp_n; i++) exp_ids[i] = first_exp[i];
        cmp_list("R2");
        chk(busy == 1'b0, "R8 busy low with done", int'(busy), 0);
        @(negedge clk);
        chk(busy == 1'b1, "R8 start taken in done cycle", int'(busy), 1);
        start = 1'b0;
        model(5);
        collect();
        cmp_list("R8");
    endtask

    initial begin
        set_hits(4'h0);
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        for (int a = 0; a < RAM_N; a++) wr(a, 5'b00000);
        t_empty_tree();
        t_full_tree();
        t_pruning();
        t_hit_mask();
        t_address_map();
        t_back_to_back();
        if (!finished) begin
            finished = 1;
            $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    end
endmodule